// File: doc/BRIEF.md
# Scrambled Register Update Sequencer

This block lets a host place a wanted byte into a device configuration register whose write path is scrambled. Writing the wanted byte straight to that register does not set it. The block instead reads the target register at address 0x74, then reads a companion status register at address 0x75. It XORs the two readback bytes together, XORs that result with the wanted byte, and writes the final byte to 0x74. The target register carries a double-data-rate output enable and a clock generator range select. The slow range spans 40 to 100 MSPS. The fast range spans 80 MSPS up to the part's top rate.

The host side is a valid/ready request carrying the wanted byte. The device side is a generic register bus that allows one transfer at a time. Each transfer is held until the device raises a ready strobe. Read data is taken in the same cycle that ready is high. Serial framing toward the device belongs to a separate block. When the write completes, the block gives a one-cycle completion pulse and keeps the byte it wrote on an output.

Top module: `xreg_update_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `req_ready` is 1 and `bus_valid`, `done` and `written_value` are all 0. A reset applied in the middle of a sequence abandons that sequence.
- R2: `req_ready` is 1 only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. A request raised while the block is busy has no effect on the sequence in progress and does not start another one.
- R3: The first transfer after a request is accepted is a read (`bus_write` = 0) at address 0x74. Its read data is captured on the edge where `bus_ready` is 1.
- R4: The second transfer is a read at address 0x75.
- R5: The third transfer is a write (`bus_write` = 1) at address 0x74. Its `bus_wdata` equals the read from 0x74 XOR the read from 0x75 XOR the wanted byte.
- R6: Once raised, `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` stay unchanged until an edge where `bus_ready` is 1. The block advances only on such an edge, so any number of wait cycles is tolerated.
- R7: `done` is high for exactly one cycle, the cycle right after the write is accepted. From that cycle on, `written_value` shows the byte written, and it keeps that value until the next write is accepted.
- R8: `bus_valid` is 0 in the `done` cycle and whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request strobe |
| req_data | input | DATA_W | Wanted register value |
| req_ready | output | 1 | Block is idle and can take a request |
| bus_valid | output | 1 | Register transfer pending |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Write data |
| bus_ready | input | 1 | Device completes the transfer this cycle |
| bus_rdata | input | DATA_W | Read data, valid when bus_ready is 1 |
| done | output | 1 | One-cycle completion pulse |
| written_value | output | DATA_W | Last byte written to the target |

## Verification
A wrong state in the controller shows up within a cycle as a wrong address, a wrong direction, or a `bus_valid` level that does not match the point reached in the sequence. Each transfer is therefore compared against its expected address and direction, both as it starts and in every wait cycle. A wrongly captured operand stays hidden until the write transfer. There it appears as a wrong `bus_wdata`, at most two transfers after the bad capture. Operand bytes are chosen so that dropping either read, or the wanted byte, from the XOR changes the written value.

// File: rtl/xreg_pkg.sv
package xreg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_TGT,
        ST_RD_STS,
        ST_WRITE,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
    } ctrl_regs_t;

endpackage

// File: rtl/xreg_seq_ctrl.sv
module xreg_seq_ctrl
    import xreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       bus_ready,
    output seq_state_e state,
    output logic       accept,
    output logic       beat,
    output logic       idle,
    output logic       done
);

    ctrl_regs_t r_q, r_d;
    logic       active;

    always_comb begin
        r_d    = r_q;
        active = (r_q.state == ST_RD_TGT) || (r_q.state == ST_RD_STS) ||
                 (r_q.state == ST_WRITE);
        accept = (r_q.state == ST_IDLE) && req_valid;
        beat   = active && bus_ready;
        unique case (r_q.state)
            ST_IDLE:   if (req_valid) r_d.state = ST_RD_TGT;
            ST_RD_TGT: if (bus_ready) r_d.state = ST_RD_STS;
            ST_RD_STS: if (bus_ready) r_d.state = ST_WRITE;
            ST_WRITE:  if (bus_ready) r_d.state = ST_DONE;
            ST_DONE:   r_d.state = ST_IDLE;
            default:   r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE};
        else        r_q <= r_d;
    end

    assign state = r_q.state;
    assign idle  = (r_q.state == ST_IDLE);
    assign done  = (r_q.state == ST_DONE);

endmodule

// File: rtl/xreg_operand_path.sv
module xreg_operand_path
    import xreg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state,
    input  logic              accept,
    input  logic              beat,
    input  logic [DATA_W-1:0] req_data,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] final_value,
    output logic [DATA_W-1:0] written_value
);

    typedef struct packed {
        logic [DATA_W-1:0] wanted;
        logic [DATA_W-1:0] tgt_rd;
        logic [DATA_W-1:0] mix;
        logic [DATA_W-1:0] shown;
    } op_regs_t;

    op_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (accept)
            r_d.wanted = req_data;
        if (beat && state == ST_RD_TGT)
            r_d.tgt_rd = bus_rdata;
        if (beat && state == ST_RD_STS)
            r_d.mix = r_q.tgt_rd ^ bus_rdata ^ r_q.wanted;
        if (beat && state == ST_WRITE)
            r_d.shown = r_q.mix;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign final_value   = r_q.mix;
    assign written_value = r_q.shown;

endmodule

// File: rtl/xreg_bus_drive.sv
module xreg_bus_drive
    import xreg_pkg::*;
#(
    parameter int              DATA_W   = 8,
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] TGT_ADDR = 'h74,
    parameter logic [ADDR_W-1:0] STS_ADDR = 'h75
) (
    input  seq_state_e        state,
    input  logic [DATA_W-1:0] final_value,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata
);

    always_comb begin
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr  = TGT_ADDR;
        bus_wdata = '0;
        unique case (state)
            ST_RD_TGT: bus_valid = 1'b1;
            ST_RD_STS: begin
                bus_valid = 1'b1;
                bus_addr  = STS_ADDR;
            end
            ST_WRITE: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_wdata = final_value;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/xreg_update_seq.sv
module xreg_update_seq
    import xreg_pkg::*;
#(
    parameter int              DATA_W   = 8,
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] TGT_ADDR = 'h74,
    parameter logic [ADDR_W-1:0] STS_ADDR = 'h75
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              done,
    output logic [DATA_W-1:0] written_value
);

    seq_state_e        state;
    logic              accept;
    logic              beat;
    logic [DATA_W-1:0] final_value;

    xreg_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .bus_ready (bus_ready),
        .state     (state),
        .accept    (accept),
        .beat      (beat),
        .idle      (req_ready),
        .done      (done)
    );

    xreg_operand_path #(.DATA_W(DATA_W)) u_ops (
        .clk           (clk),
        .rst_n         (rst_n),
        .state         (state),
        .accept        (accept),
        .beat          (beat),
        .req_data      (req_data),
        .bus_rdata     (bus_rdata),
        .final_value   (final_value),
        .written_value (written_value)
    );

    xreg_bus_drive #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .TGT_ADDR (TGT_ADDR),
        .STS_ADDR (STS_ADDR)
    ) u_bus (
        .state       (state),
        .final_value (final_value),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata)
    );

endmodule

// File: rtl/xreg_update_seq_chk.sv
module xreg_update_seq_chk #(
    parameter int              DATA_W   = 8,
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] TGT_ADDR = 'h74
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ready,
    input logic              done,
    input logic [DATA_W-1:0] written_value
);

    a_r2_busy_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !req_ready);

    a_r3_first_is_target_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_valid) |-> (!bus_write && bus_addr == TGT_ADDR));

    a_r6_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
                                       $stable(bus_write) && $stable(bus_wdata)));

    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_valid && bus_ready && bus_write));

    a_r5_shown_matches_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> written_value == $past(bus_wdata));

    a_r8_quiet_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_valid);

endmodule

bind xreg_update_seq xreg_update_seq_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .TGT_ADDR (TGT_ADDR)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .bus_valid     (bus_valid),
    .bus_write     (bus_write),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_ready     (bus_ready),
    .done          (done),
    .written_value (written_value)
);

// File: tb/xreg_update_seq_test.sv
module xreg_update_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_data = 8'h00;
    logic       req_ready;
    logic       bus_valid;
    logic       bus_write;
    logic [7:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       bus_ready = 1'b0;
    logic [7:0] bus_rdata = 8'h00;
    logic       done;
    logic [7:0] written_value;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    xreg_update_seq uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_data      (req_data),
        .req_ready     (req_ready),
        .bus_valid     (bus_valid),
        .bus_write     (bus_write),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_ready     (bus_ready),
        .bus_rdata     (bus_rdata),
        .done          (done),
        .written_value (written_value)
    );

    // {wanted, read of 0x74, read of 0x75, wait cycles}
    localparam logic [31:0] VEC [6] = '{
        32'h5A_00_00_00,
        32'h00_C3_00_01,
        32'h00_00_3C_02,
        32'hA5_0F_F0_00,
        32'hFF_FF_FF_03,
        32'h81_42_24_05
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic serve(input logic wr, input logic [7:0] addr, input logic [7:0] wd,
                         input logic [7:0] rd, input int waits, input string tag);
        chk({tag, " valid"}, bus_valid, 1);
        chk({tag, " dir"}, bus_write, wr);
        chk({tag, " addr"}, bus_addr, addr);
        if (wr) chk({tag, " wdata"}, bus_wdata, wd);
        chk("R2 ready low while busy", req_ready, 0);
        for (int i = 0; i < waits; i++) begin
            bus_ready = 1'b0;
            @(posedge clk); @(negedge clk);
            chk("R6 valid held", bus_valid, 1);
            chk("R6 addr held", bus_addr, addr);
            chk("R6 dir held", bus_write, wr);
            if (wr) chk("R6 wdata held", bus_wdata, wd);
        end
        bus_ready = 1'b1;
        bus_rdata = rd;
        @(posedge clk); @(negedge clk);
        bus_ready = 1'b0;
        bus_rdata = 8'h00;
    endtask

    task automatic run_seq(input logic [7:0] want, input logic [7:0] r74,
                           input logic [7:0] r75, input int waits);
        logic [7:0] exp;
        exp = r74 ^ r75 ^ want;
        chk("R2 ready when idle", req_ready, 1);
        req_valid = 1'b1;
        req_data  = want;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        serve(1'b0, 8'h74, 8'h00, r74, waits, "R3 target read");
        serve(1'b0, 8'h75, 8'h00, r75, waits, "R4 status read");
        serve(1'b1, 8'h74, exp, 8'h00, waits, "R5 write");
        chk("R7 done pulse", done, 1);
        chk("R7 written_value", written_value, exp);
        chk("R8 no transfer on done", bus_valid, 0);
        @(posedge clk); @(negedge clk);
        chk("R7 done one cycle", done, 0);
        chk("R7 written_value held", written_value, exp);
        chk("R2 back to idle", req_ready, 1);
        chk("R8 idle quiet", bus_valid, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset req_ready", req_ready, 1);
        chk("R1 reset bus_valid", bus_valid, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset written_value", written_value, 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 after reset idle", req_ready, 1);
        chk("R8 after reset quiet", bus_valid, 0);

        for (int v = 0; v < 6; v++)
            run_seq(VEC[v][31:24], VEC[v][23:16], VEC[v][15:8], int'(VEC[v][7:0]));

        // R2: a second request during a busy sequence is ignored
        req_valid = 1'b1;
        req_data  = 8'h11;
        @(posedge clk); @(negedge clk);
        req_data  = 8'h3C;
        serve(1'b0, 8'h74, 8'h00, 8'h22, 2, "R3 target read under busy req");
        req_valid = 1'b0;
        serve(1'b0, 8'h75, 8'h00, 8'h44, 0, "R4 status read under busy req");
        serve(1'b1, 8'h74, 8'h11 ^ 8'h22 ^ 8'h44, 8'h00, 1, "R2 busy req ignored in write");
        chk("R7 done after busy test", done, 1);
        @(posedge clk); @(negedge clk);
        chk("R2 no extra sequence", bus_valid, 0);
        @(posedge clk); @(negedge clk);
        chk("R2 still idle", bus_valid, 0);
        chk("R7 value kept across idle", written_value, 8'h77);

        // R1: reset in the middle of a sequence
        req_valid = 1'b1;
        req_data  = 8'h99;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        serve(1'b0, 8'h74, 8'h00, 8'h12, 0, "R3 target read before abort");
        chk("R4 status read before abort", bus_addr, 8'h75);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 abort bus_valid", bus_valid, 0);
        chk("R1 abort req_ready", req_ready, 1);
        chk("R1 abort written_value", written_value, 0);
        chk("R1 abort done", done, 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        run_seq(8'h6E, 8'h01, 8'h80, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule